// File: doc/BRIEF.md
# CAN Controller Configuration Register Bank

This block holds the software-visible configuration state of a CAN controller. It contains a mode control word, a bit-timing word, a sticky event word that clears when read, and one pin-control word for each of the transmit pin and the receive pin. Software reaches these registers over a simple synchronous bus. The bus has an address, a write strobe with write data, and a read strobe. Read data appears on the cycle after the read strobe and holds until the next read. The protocol engine raises event bits through a set vector. The two pin levels enter as plain inputs.

Write permission follows the mode bits. The bit-timing word changes only while both initialisation and configuration-enable are set. The pin-control words change only while initialisation is clear. When software takes the block out of initialisation, hardware overwrites both pin-control words with fixed values. A pin-control value written before that exit is therefore lost, and only writes made after the exit remain.

Top module: `can_cfg_regbank`

## Requirements
- R1: After reset the registers read as follows: control 0x00000001, bit timing 0x00002301, status 0, transmit pin control 0x0000000F and receive pin control 0x00000009, with both pin levels high.
- R2: The control register (offset 0x00) stores only bit 0 (initialisation) and bit 6 (configuration enable). Every other bit reads 0. The `init_mode` output follows bit 0.
- R3: A write to the bit-timing register (offset 0x0C) takes effect only when the control register holds bit 0 = 1 and bit 6 = 1. In every other state the write is ignored.
- R4: The pin-control registers (transmit 0x1C, receive 0x20) accept writes whenever bit 0 of the control register is 0, whatever bit 6 holds. While bit 0 is 1, writes to them are ignored.
- R5: On the control write that changes bit 0 from 1 to 0, the transmit pin-control register is forced so that output value (bit 1), direction (bit 2) and function enable (bit 3) are 1 and open-drain (bit 16) is 0. With the pin high it then reads 0x0000000F.
- R6: On that same exit, the receive pin-control register is forced so that function enable (bit 3) is 1 and direction (bit 2), output value (bit 1) and open-drain (bit 16) are 0. With the pin high it then reads 0x00000009.
- R7: A read of the status register (offset 0x04) returns the accumulated event bits and clears them.
- R8: An event bit raised in the same cycle as a status read survives the clear and is returned by the next read.
- R9: Reads of unmapped offsets return 0, and writes to them change no register.
- R10: Bit 0 of each pin-control register always shows the live level of its pin. Writes to that bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_rdata | output | DATA_W | Registered read data |
| stat_set | input | STAT_W | Event bits from the protocol engine, one cycle per event |
| tx_pin_lvl | input | 1 | Sampled level of the transmit pin |
| rx_pin_lvl | input | 1 | Sampled level of the receive pin |
| init_mode | output | 1 | Initialisation bit of the control register |
| bit_timing | output | DATA_W | Current bit-timing word |
| tx_io_ctl | output | DATA_W | Current transmit pin-control word |
| rx_io_ctl | output | DATA_W | Current receive pin-control word |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 32-bit data and an 8-bit event vector. The 8-bit address leaves offsets such as 0x08 and 0xFC unmapped, so ignored accesses can be tested. The full event vector lets the bench raise one event bit at the same moment it reads other bits, which tests the case where a set and a clear collide. The default bit-timing reset value is the one the bench expects after reset. The bench runs several entries into and exits from initialisation, with different control-bit combinations and with each pin high and low. This covers the forced values, the writes that are ignored while locked, and the writes that are kept after an exit.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;

    // Register offsets (byte addresses)
    localparam int unsigned OFF_CTRL = 32'h00;
    localparam int unsigned OFF_STAT = 32'h04;
    localparam int unsigned OFF_BTIM = 32'h0C;
    localparam int unsigned OFF_TXIO = 32'h1C;
    localparam int unsigned OFF_RXIO = 32'h20;

    // Control word bit positions
    localparam int unsigned CTRL_INIT_BIT = 0;
    localparam int unsigned CTRL_CCE_BIT  = 6;

    // Pin-control word bit positions
    localparam int unsigned IO_PIN_BIT  = 0;
    localparam int unsigned IO_OUT_BIT  = 1;
    localparam int unsigned IO_DIR_BIT  = 2;
    localparam int unsigned IO_FUNC_BIT = 3;
    localparam int unsigned IO_OD_BIT   = 16;

    // Number of pin-control registers
    localparam int unsigned NUM_IO = 2;

    typedef struct packed {
        logic od;
        logic func;
        logic dir;
        logic out;
    } io_fields_t;

endpackage

// File: rtl/can_mode_ctl.sv
module can_mode_ctl #(
    parameter int unsigned        DATA_W     = 32,
    parameter logic [DATA_W-1:0]  BTIM_RESET = 'h2301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              wr_init,
    input  logic              wr_cce,
    input  logic              btim_we,
    input  logic [DATA_W-1:0] btim_wdata,
    output logic              init_o,
    output logic              cce_o,
    output logic              init_exit_o,
    output logic [DATA_W-1:0] btim_o
);

    typedef struct packed {
        logic              init;
        logic              cce;
        logic [DATA_W-1:0] btim;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.init = wr_init;
            st_d.cce  = wr_cce;
        end
        // bit timing is open only with both mode bits set
        if (btim_we && st_q.init && st_q.cce) begin
            st_d.btim = btim_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.init <= 1'b1;
            st_q.cce  <= 1'b0;
            st_q.btim <= BTIM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_o      = st_q.init;
    assign cce_o       = st_q.cce;
    assign btim_o      = st_q.btim;
    assign init_exit_o = ctrl_we && st_q.init && !wr_init;

    // R2: a clearing write leaves initialisation on the next cycle
    assert_init_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_exit_o |=> !init_o);

endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              rd_clr_i,
    output logic [STAT_W-1:0] stat_o
);

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) begin
            st_d.bits = '0;
        end
        // a set in the read cycle wins over the clear
        st_d.bits = st_d.bits | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.bits;

    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (stat_o == $past(set_i)));

    assert_stat_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/can_io_ctl.sv
module can_io_ctl
    import can_cfg_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter bit          FORCE_OUT = 1'b1,
    parameter bit          FORCE_DIR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  io_fields_t        wr_i,
    input  logic              init_i,
    input  logic              init_exit_i,
    input  logic              pin_i,
    output logic [DATA_W-1:0] word_o
);

    localparam io_fields_t FORCED = '{od: 1'b0, func: 1'b1, dir: FORCE_DIR, out: FORCE_OUT};

    io_fields_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_exit_i) begin
            st_d = FORCED;
        end else if (we_i && !init_i) begin
            st_d = wr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FORCED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        word_o              = '0;
        word_o[IO_PIN_BIT]  = pin_i;
        word_o[IO_OUT_BIT]  = st_q.out;
        word_o[IO_DIR_BIT]  = st_q.dir;
        word_o[IO_FUNC_BIT] = st_q.func;
        word_o[IO_OD_BIT]   = st_q.od;
    end

    // R5 (transmit) / R6 (receive): forced fields after leaving initialisation
    assert_io_forced_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_exit_i |=> (st_q == FORCED));

    assert_io_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && !init_exit_i) |=> $stable(st_q));

endmodule

// File: rtl/can_cfg_regbank.sv
module can_cfg_regbank
    import can_cfg_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 8,
    parameter int unsigned        DATA_W     = 32,
    parameter int unsigned        STAT_W     = 8,
    parameter logic [DATA_W-1:0]  BTIM_RESET = 'h2301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] stat_set,
    input  logic              tx_pin_lvl,
    input  logic              rx_pin_lvl,
    output logic              init_mode,
    output logic [DATA_W-1:0] bit_timing,
    output logic [DATA_W-1:0] tx_io_ctl,
    output logic [DATA_W-1:0] rx_io_ctl
);

    localparam int unsigned IO_TX = 0;
    localparam int unsigned IO_RX = 1;

    // address decode
    logic hit_ctrl, hit_stat, hit_btim, any_hit;
    logic [NUM_IO-1:0] hit_io;

    assign hit_ctrl     = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_stat     = (bus_addr == ADDR_W'(OFF_STAT));
    assign hit_btim     = (bus_addr == ADDR_W'(OFF_BTIM));
    assign hit_io[IO_TX] = (bus_addr == ADDR_W'(OFF_TXIO));
    assign hit_io[IO_RX] = (bus_addr == ADDR_W'(OFF_RXIO));
    assign any_hit      = hit_ctrl | hit_stat | hit_btim | (|hit_io);

    // mode and bit timing
    logic init_q, cce_q, init_exit;

    can_mode_ctl #(
        .DATA_W    (DATA_W),
        .BTIM_RESET(BTIM_RESET)
    ) i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_wr && hit_ctrl),
        .wr_init    (bus_wdata[CTRL_INIT_BIT]),
        .wr_cce     (bus_wdata[CTRL_CCE_BIT]),
        .btim_we    (bus_wr && hit_btim),
        .btim_wdata (bus_wdata),
        .init_o     (init_q),
        .cce_o      (cce_q),
        .init_exit_o(init_exit),
        .btim_o     (bit_timing)
    );

    // status
    logic [STAT_W-1:0] stat_q;

    can_stat_reg #(
        .STAT_W(STAT_W)
    ) i_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (stat_set),
        .rd_clr_i(bus_rd && hit_stat),
        .stat_o  (stat_q)
    );

    // pin-control registers
    io_fields_t        io_wr;
    logic [NUM_IO-1:0] io_pin;
    logic [DATA_W-1:0] io_word [NUM_IO];

    assign io_wr.od    = bus_wdata[IO_OD_BIT];
    assign io_wr.func  = bus_wdata[IO_FUNC_BIT];
    assign io_wr.dir   = bus_wdata[IO_DIR_BIT];
    assign io_wr.out   = bus_wdata[IO_OUT_BIT];
    assign io_pin[IO_TX] = tx_pin_lvl;
    assign io_pin[IO_RX] = rx_pin_lvl;

    for (genvar k = 0; k < NUM_IO; k++) begin : g_io
        localparam bit IS_TX = (k == IO_TX);
        can_io_ctl #(
            .DATA_W   (DATA_W),
            .FORCE_OUT(IS_TX),
            .FORCE_DIR(IS_TX)
        ) i_io (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_i       (bus_wr && hit_io[k]),
            .wr_i       (io_wr),
            .init_i     (init_q),
            .init_exit_i(init_exit),
            .pin_i      (io_pin[k]),
            .word_o     (io_word[k])
        );
    end

    assign tx_io_ctl = io_word[IO_TX];
    assign rx_io_ctl = io_word[IO_RX];
    assign init_mode = init_q;

    // registered read path
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[CTRL_INIT_BIT] = init_q;
            rd_mux[CTRL_CCE_BIT]  = cce_q;
        end
        if (hit_stat)      rd_mux = DATA_W'(stat_q);
        if (hit_btim)      rd_mux = bit_timing;
        if (hit_io[IO_TX]) rd_mux = io_word[IO_TX];
        if (hit_io[IO_RX]) rd_mux = io_word[IO_RX];
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0));

    assert_btim_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_btim && !(init_mode && cce_q)) |=> $stable(bit_timing));

endmodule

// File: tb/test_can_cfg_regbank.sv
`timescale 1ns/1ps
module test_can_cfg_regbank;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned STAT_W = 8;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_BTIM = 8'h0C;
    localparam logic [7:0] A_TXIO = 8'h1C;
    localparam logic [7:0] A_RXIO = 8'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [STAT_W-1:0] stat_set = '0;
    logic              tx_pin_lvl = 1'b1;
    logic              rx_pin_lvl = 1'b1;
    logic              init_mode;
    logic [DATA_W-1:0] bit_timing;
    logic [DATA_W-1:0] tx_io_ctl;
    logic [DATA_W-1:0] rx_io_ctl;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    can_cfg_regbank #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .STAT_W(STAT_W)
    ) i_can_cfg_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .stat_set  (stat_set),
        .tx_pin_lvl(tx_pin_lvl),
        .rx_pin_lvl(rx_pin_lvl),
        .init_mode (init_mode),
        .bit_timing(bit_timing),
        .tx_io_ctl (tx_io_ctl),
        .rx_io_ctl (rx_io_ctl)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [DATA_W-1:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse_set(input logic [STAT_W-1:0] v);
        @(negedge clk);
        stat_set = v;
        @(negedge clk);
        stat_set = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl reset", A_CTRL, 32'h1);
        rd_chk("R1 btim reset", A_BTIM, 32'h2301);
        rd_chk("R1 stat reset", A_STAT, 32'h0);
        rd_chk("R1 txio reset", A_TXIO, 32'hF);
        rd_chk("R1 rxio reset", A_RXIO, 32'h9);
        chk("R2 init_mode port after reset", 32'(init_mode), 32'h1);
    endtask

    task automatic t_bit_timing;
        wr(A_BTIM, 32'h1234);                       // init only
        rd_chk("R3 btim locked with init only", A_BTIM, 32'h2301);
        wr(A_CTRL, 32'h41);
        rd_chk("R2 ctrl 0x41", A_CTRL, 32'h41);
        wr(A_BTIM, 32'h00AB_CDEF);
        rd_chk("R3 btim open", A_BTIM, 32'h00AB_CDEF);
        chk("R3 bit_timing port", bit_timing, 32'h00AB_CDEF);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R2 other ctrl bits read zero", A_CTRL, 32'h41);
        wr(A_CTRL, 32'h40);                         // leave init, keep cce
        chk("R2 init_mode port cleared", 32'(init_mode), 32'h0);
        wr(A_BTIM, 32'h55);
        rd_chk("R3 btim locked with cce only", A_BTIM, 32'h00AB_CDEF);
    endtask

    task automatic t_io;
        rd_chk("R5 tx forced after exit", A_TXIO, 32'hF);
        rd_chk("R6 rx forced after exit", A_RXIO, 32'h9);
        wr(A_TXIO, 32'h0001_0002);                  // cce still set
        rd_chk("R4 tx write while init clear", A_TXIO, 32'h0001_0003);
        wr(A_RXIO, 32'h0000_000C);
        rd_chk("R4 rx write while init clear", A_RXIO, 32'h0000_000D);
        wr(A_RXIO, 32'h0000_000E);                  // bit0 = 0 written, pin high
        rd_chk("R10 pin bit not writable", A_RXIO, 32'h0000_000F);
        wr(A_CTRL, 32'h41);
        wr(A_TXIO, 32'h0);
        rd_chk("R4 tx write ignored in init", A_TXIO, 32'h0001_0003);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 tx forced on exit", A_TXIO, 32'hF);
        rd_chk("R6 rx forced on exit", A_RXIO, 32'h9);
        chk("R5 tx port forced", tx_io_ctl, 32'hF);
        wr(A_TXIO, 32'h0);
        rd_chk("R4 tx write after exit persists", A_TXIO, 32'h1);
        @(negedge clk);
        tx_pin_lvl = 1'b0;
        rd_chk("R10 tx pin level low", A_TXIO, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 tx forced with pin low", A_TXIO, 32'hE);
        @(negedge clk);
        tx_pin_lvl = 1'b1;
        rx_pin_lvl = 1'b0;
        rd_chk("R10 rx pin level low", A_RXIO, 32'h8);
        @(negedge clk);
        rx_pin_lvl = 1'b1;
    endtask

    task automatic t_status;
        pulse_set(8'h03);
        rd_chk("R7 status read", A_STAT, 32'h03);
        rd_chk("R7 status cleared", A_STAT, 32'h00);
        pulse_set(8'h03);
        @(negedge clk);
        bus_addr = A_STAT; bus_rd = 1'b1; stat_set = 8'h10;
        @(negedge clk);
        bus_rd = 1'b0; stat_set = '0;
        chk("R8 read during set returns old bits", bus_rdata, 32'h03);
        rd_chk("R8 colliding set survives", A_STAT, 32'h10);
        rd_chk("R7 status empty again", A_STAT, 32'h00);
    endtask

    task automatic t_unmapped;
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk("R9 unmapped 0x08 reads zero", 8'h08, 32'h0);
        rd_chk("R9 unmapped 0xFC reads zero", 8'hFC, 32'h0);
        rd_chk("R9 ctrl untouched", A_CTRL, 32'h0);
        rd_chk("R9 btim untouched", A_BTIM, 32'h00AB_CDEF);
        rd_chk("R9 txio untouched", A_TXIO, 32'hF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bit_timing();
        t_io();
        t_status();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule